// File: doc/BRIEF.md
# Truncating Single-Precision Fused Multiply-Add Lane

This block is one 32-bit lane of a pipelined fused multiply-add datapath for single-precision floating point. It computes A*B+C with one rounding step at the end, and that step always truncates toward zero. Several copies placed side by side form a wider SIMD unit, for example four lanes across a 128-bit operand.

An operation is accepted every clock cycle and leaves six register stages later with its valid bit. The stages pair up: two for the exact significand product and the addend alignment, two for the add and the leading-zero count, and two for normalization and packing. Denormal operands count as zero, tiny results flush to a signed zero, and overflow saturates to the largest finite magnitude. A merge port at the last stage lets an integer result from another unit take the output slot in place of the floating-point result.

Top module: `fma_lane_trunc`

## Requirements
- R1: For normal, finite operands the result is the exact value A*B+C truncated toward zero to the 24-bit significand (IEEE single format: sign bit 31, biased exponent bits 30:23, fraction bits 22:0), even when the addend lies far below the product's last bit.
- R2: An operation sampled with `in_valid` high on a rising edge appears on `out_res` with `out_valid` high right after the sixth rising edge counting the sampling edge. `out_valid` is low in every other cycle unless `int_sel` acts. One operation is accepted every cycle.
- R3: If any operand is a NaN, or the product is infinity times zero, or an infinite product meets an infinite addend of opposite sign, the result is the quiet NaN 0x7FC00000.
- R4: Otherwise an infinite product or an infinite addend gives an infinity: the product's sign if the product is infinite, else the addend's sign.
- R5: An exact zero sum gives +0 (0x00000000), except that a -0 product plus a -0 addend gives -0 (0x80000000).
- R6: A finite result whose biased exponent would reach 255 or more saturates to 0x7F7FFFFF or 0xFF7FFFFF, by the sign of the exact result.
- R7: Operands with a zero exponent field count as zero of their sign. A nonzero result whose biased exponent would be 0 or lower becomes a zero carrying the sign of the exact result.
- R8: When `int_sel` is high on a rising edge, right after that edge `out_res` equals `int_val` as it was sampled and `out_valid` is high. The integer result takes priority over a floating-point result due in the same cycle.
- R9: During synchronous reset (`rst_n` low on an edge), `out_valid` and `out_res` are set to zero.
- R10: When the sum cancels, so that the leading one falls many places below the larger operand's leading one, the result is normalized and its exponent lowered by that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on op_a, op_b, op_c are to be taken this cycle |
| op_a | input | 32 | Multiplicand A |
| op_b | input | 32 | Multiplier B |
| op_c | input | 32 | Addend C |
| int_sel | input | 1 | Replace the next output with int_val |
| int_val | input | 32 | Integer result to merge into the output slot |
| out_valid | output | 1 | out_res holds a result |
| out_res | output | 32 | Truncated FMA result or merged integer result |

## Verification
A floating-point result is due right after the sixth rising edge, counting the one that samples the operands. A merged integer result is due right after the one edge that samples `int_sel`. Each scenario task drives its inputs on a falling edge, then counts falling edges one by one: five after the capturing edge for the fused path, one for the merge path. It reads `out_res` and `out_valid` only at those falling edges, in the middle of the cycle. The latency scenario also checks that the valid bit is low one cycle early and one cycle late. The streaming scenario issues operations on consecutive cycles and expects each result exactly one cycle after the one before.

// File: rtl/fma_pkg.sv
`timescale 1ns/1ps
// Package: types shared across the truncating FMA lane stages.
// Assumes: nothing beyond IEEE single-style field layout chosen by parameters.
package fma_pkg;
    // Special-case outcome decided at operand decode, carried to packing.
    typedef struct packed {
        logic nan;      // result is the default quiet NaN
        logic inf;      // result is an infinity
        logic inf_neg;  // sign of that infinity
    } fma_spec_t;
endpackage

// File: rtl/fma_mul_align.sv
`timescale 1ns/1ps
// Module: fma_mul_align - stages 1 and 2 of the lane.
// Stage 1 decodes operands, flushes denormals to zero, forms the exact
// significand product and the exponents, and classifies special cases.
// Stage 2 aligns product and addend in a common window, right-shifting
// the one with the smaller exponent and folding lost bits into a sticky flag.
// Assumes: bits shifted out can only be nonzero when the shifted operand is
// far below the unshifted one (guard bits below the product absorb small shifts).
module fma_mul_align
    import fma_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   op_a,
    input  logic [EXP_W+FRAC_W:0]   op_b,
    input  logic [EXP_W+FRAC_W:0]   op_c,
    output logic                    al_valid,
    output logic [2*FRAC_W+2*FRAC_W+7:0] al_x,   // aligned product
    output logic [2*FRAC_W+2*FRAC_W+7:0] al_y,   // aligned addend
    output logic                    al_sticky,
    output logic signed [EXP_W+3:0] al_emax,
    output logic                    al_sp,
    output logic                    al_sc,
    output fma_spec_t               al_spec
);
    localparam int DW      = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int GUARD_W = SIG_W + 2;
    localparam int WIN_W   = PROD_W + GUARD_W + 2;
    localparam int ONE_POS = PROD_W - 2 + GUARD_W;
    localparam int EI_W    = EXP_W + 4;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;

    // Decoded operand fields
    logic [EXP_W-1:0] ea, eb, ec;
    logic [FRAC_W-1:0] fa, fb, fc;
    logic za, zb, zc, ia, ib, ic, na, nb, nc, pinf;
    logic [SIG_W-1:0] sig_a, sig_b, sig_c;
    logic signed [EI_W-1:0] ep_n;

    // Stage 1 registers
    logic                   v1, sp1, sc1;
    logic [PROD_W-1:0]      prod1;
    logic [SIG_W-1:0]       sigc1;
    logic signed [EI_W-1:0] ep1, ec1;
    fma_spec_t              spec1;

    // Split fields, classify, flush denormals to zero significands.
    always_comb begin
        ea = op_a[DW-2:FRAC_W];  fa = op_a[FRAC_W-1:0];
        eb = op_b[DW-2:FRAC_W];  fb = op_b[FRAC_W-1:0];
        ec = op_c[DW-2:FRAC_W];  fc = op_c[FRAC_W-1:0];
        za = (ea == '0);  zb = (eb == '0);  zc = (ec == '0);
        ia = (&ea) && (fa == '0);  na = (&ea) && (fa != '0);
        ib = (&eb) && (fb == '0);  nb = (&eb) && (fb != '0);
        ic = (&ec) && (fc == '0);  nc = (&ec) && (fc != '0);
        pinf  = ia | ib;
        sig_a = za ? '0 : {1'b1, fa};
        sig_b = zb ? '0 : {1'b1, fb};
        sig_c = zc ? '0 : {1'b1, fc};
        ep_n  = EI_W'(ea) + EI_W'(eb) - EI_W'(BIAS);
    end

    // Stage 1: capture exact product, exponents (zeros follow the other side) and specials.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; sp1 <= 1'b0; sc1 <= 1'b0; prod1 <= '0; sigc1 <= '0;
            ep1 <= '0; ec1 <= '0; spec1 <= '0;
        end else begin
            v1    <= in_valid;
            sp1   <= op_a[DW-1] ^ op_b[DW-1];
            sc1   <= op_c[DW-1];
            prod1 <= PROD_W'(sig_a) * PROD_W'(sig_b);
            sigc1 <= sig_c;
            ep1   <= (za | zb) ? EI_W'(ec) : ep_n;
            ec1   <= zc ? ep_n : EI_W'(ec);
            spec1.nan <= na | nb | nc | (pinf & (za | zb))
                       | (pinf & ic & (op_a[DW-1] ^ op_b[DW-1] ^ op_c[DW-1]));
            spec1.inf     <= pinf | ic;
            spec1.inf_neg <= pinf ? (op_a[DW-1] ^ op_b[DW-1]) : op_c[DW-1];
        end
    end

    // Alignment datapath
    logic signed [EI_W-1:0] d;
    logic                   dneg, lost;
    logic [EI_W-1:0]        mag;
    logic [WIN_W-1:0]       pw, cw, src, shv;

    // Shift the smaller-exponent operand right; record any bits lost.
    always_comb begin
        d    = ep1 - ec1;
        dneg = (d < 0);
        mag  = dneg ? -d : d;
        pw   = WIN_W'(prod1) << GUARD_W;
        cw   = WIN_W'(sigc1) << (ONE_POS - FRAC_W);
        src  = dneg ? pw : cw;
        if (mag >= EI_W'(WIN_W)) begin
            shv  = '0;
            lost = |src;
        end else begin
            shv  = src >> mag;
            lost = ((shv << mag) != src);
        end
    end

    // Stage 2: capture aligned pair, larger exponent and sticky.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_valid <= 1'b0; al_x <= '0; al_y <= '0; al_sticky <= 1'b0;
            al_emax <= '0; al_sp <= 1'b0; al_sc <= 1'b0; al_spec <= '0;
        end else begin
            al_valid  <= v1;
            al_x      <= dneg ? shv : pw;
            al_y      <= dneg ? cw : shv;
            al_sticky <= lost;
            al_emax   <= dneg ? ec1 : ep1;
            al_sp     <= sp1;
            al_sc     <= sc1;
            al_spec   <= spec1;
        end
    end
endmodule

// File: rtl/fma_add_lzc.sv
`timescale 1ns/1ps
// Module: fma_add_lzc - stages 3 and 4 of the lane.
// Stage 3 adds or subtracts the aligned magnitudes (larger minus smaller,
// sticky taken as one unit at the window bottom) and fixes the sign.
// Stage 4 counts leading zeros of the magnitude sum.
// Assumes: a set sticky always belongs to the smaller aligned operand.
module fma_add_lzc
    import fma_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    al_valid,
    input  logic [4*FRAC_W+7:0]     al_x,
    input  logic [4*FRAC_W+7:0]     al_y,
    input  logic                    al_sticky,
    input  logic signed [EXP_W+3:0] al_emax,
    input  logic                    al_sp,
    input  logic                    al_sc,
    input  fma_spec_t               al_spec,
    output logic                    lz_valid,
    output logic [4*FRAC_W+7:0]     lz_sum,
    output logic [$clog2(4*FRAC_W+9)-1:0] lz_cnt,
    output logic                    lz_sign,
    output logic                    lz_zneg,
    output logic signed [EXP_W+3:0] lz_emax,
    output fma_spec_t               lz_spec
);
    localparam int WIN_W = 4 * FRAC_W + 8;
    localparam int LZ_W  = $clog2(WIN_W + 1);

    logic                   sub, ge;
    logic [WIN_W-1:0]       sum_n;

    // Stage 3 registers
    logic                   v3, sgn3, zneg3;
    logic [WIN_W-1:0]       sum3;
    logic signed [EXP_W+3:0] emax3;
    fma_spec_t              spec3;

    // Effective add or subtract of magnitudes; sticky lowers a difference by one unit.
    always_comb begin
        sub   = al_sp ^ al_sc;
        ge    = (al_x >= al_y);
        if (!sub)
            sum_n = al_x + al_y;
        else if (ge)
            sum_n = al_x - al_y - WIN_W'(al_sticky);
        else
            sum_n = al_y - al_x - WIN_W'(al_sticky);
    end

    // Stage 3: capture magnitude, sign of a nonzero result and sign of an exact zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v3 <= 1'b0; sum3 <= '0; sgn3 <= 1'b0; zneg3 <= 1'b0; emax3 <= '0; spec3 <= '0;
        end else begin
            v3    <= al_valid;
            sum3  <= sum_n;
            sgn3  <= sub ? (ge ? al_sp : al_sc) : al_sp;
            zneg3 <= !sub & al_sp;
            emax3 <= al_emax;
            spec3 <= al_spec;
        end
    end

    // Subtraction never underflows the window. (R1)
    assert_no_borrow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (al_valid && (al_sp ^ al_sc) && al_sticky) |=> (sum3 != '0));

    logic [LZ_W-1:0] cnt_n;

    // Leading-zero count: highest set bit wins.
    always_comb begin
        cnt_n = LZ_W'(WIN_W);
        for (int i = 0; i < WIN_W; i++)
            if (sum3[i]) cnt_n = LZ_W'(WIN_W - 1 - i);
    end

    // Stage 4: capture count alongside the sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lz_valid <= 1'b0; lz_sum <= '0; lz_cnt <= '0; lz_sign <= 1'b0;
            lz_zneg <= 1'b0; lz_emax <= '0; lz_spec <= '0;
        end else begin
            lz_valid <= v3;
            lz_sum   <= sum3;
            lz_cnt   <= cnt_n;
            lz_sign  <= sgn3;
            lz_zneg  <= zneg3;
            lz_emax  <= emax3;
            lz_spec  <= spec3;
        end
    end
endmodule

// File: rtl/fma_norm_pack.sv
`timescale 1ns/1ps
// Module: fma_norm_pack - stages 5 and 6 of the lane.
// Stage 5 shifts the leading one to the top and truncates to the fraction
// width, adjusting the exponent. Stage 6 applies specials, zero sign,
// saturation and flush-to-zero, then merges an integer result if selected.
// Assumes: the leading one of the sum sits at most three places above the
// product's unit position.
module fma_norm_pack
    import fma_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lz_valid,
    input  logic [4*FRAC_W+7:0]     lz_sum,
    input  logic [$clog2(4*FRAC_W+9)-1:0] lz_cnt,
    input  logic                    lz_sign,
    input  logic                    lz_zneg,
    input  logic signed [EXP_W+3:0] lz_emax,
    input  fma_spec_t               lz_spec,
    input  logic                    int_sel,
    input  logic [EXP_W+FRAC_W:0]   int_val,
    output logic                    out_valid,
    output logic [EXP_W+FRAC_W:0]   out_res
);
    localparam int DW      = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int WIN_W   = 4 * FRAC_W + 8;
    localparam int ONE_POS = 2 * SIG_W - 2 + SIG_W + 2;
    localparam int EI_W    = EXP_W + 4;
    localparam logic signed [EI_W-1:0] E_OFS = EI_W'(WIN_W - 1 - ONE_POS);
    localparam logic signed [EI_W-1:0] E_TOP = EI_W'((1 << EXP_W) - 1);
    localparam logic signed [EI_W-1:0] E_LOW = '0;
    localparam logic [DW-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic                   v5, sgn5, zero5, zneg5;
    logic [FRAC_W-1:0]      frac5;
    logic signed [EI_W-1:0] e5;
    fma_spec_t              spec5;
    logic [DW-1:0]          packed_n;

    // Stage 5: normalize, truncate the fraction, derive the biased exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v5 <= 1'b0; sgn5 <= 1'b0; zero5 <= 1'b0; zneg5 <= 1'b0;
            frac5 <= '0; e5 <= '0; spec5 <= '0;
        end else begin
            v5    <= lz_valid;
            frac5 <= FRAC_W'((lz_sum << lz_cnt) >> (WIN_W - 1 - FRAC_W));
            e5    <= lz_emax + E_OFS - EI_W'(lz_cnt);
            zero5 <= (lz_sum == '0);
            sgn5  <= lz_sign;
            zneg5 <= lz_zneg;
            spec5 <= lz_spec;
        end
    end

    // Pick the final encoding by priority: NaN, infinity, zero, saturate, flush, normal.
    always_comb begin
        if (spec5.nan)        packed_n = QNAN;
        else if (spec5.inf)   packed_n = {spec5.inf_neg, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (zero5)       packed_n = {zneg5, {(DW-1){1'b0}}};
        else if (e5 >= E_TOP) packed_n = {sgn5, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        else if (e5 <= E_LOW) packed_n = {sgn5, {(DW-1){1'b0}}};
        else                  packed_n = {sgn5, e5[EXP_W-1:0], frac5};
    end

    // Stage 6: output register with the integer merge port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= v5 | int_sel;
            out_res   <= int_sel ? int_val : packed_n;
        end
    end

    // Any NaN leaving the float path is the default quiet NaN. (R3)
    assert_nan_canon_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(int_sel) && (&out_res[DW-2:FRAC_W]) && (out_res[FRAC_W-1:0] != '0))
        |-> (out_res == QNAN));
    // No denormal leaves the float path. (R7)
    assert_no_denorm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(int_sel) && (out_res[DW-2:FRAC_W] == '0)) |-> (out_res[FRAC_W-1:0] == '0));
    // An all-ones exponent only comes from a special case, never from overflow. (R6)
    assert_sat_no_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_sel && !spec5.nan && !spec5.inf) |=> (!(&out_res[DW-2:FRAC_W])));
endmodule

// File: rtl/fma_lane_trunc.sv
`timescale 1ns/1ps
// Module: fma_lane_trunc - one lane of a truncating single-precision FMA.
// Computes A*B+C with a single truncation toward zero; six register stages,
// one operation per cycle; an integer result can take the output slot.
// Assumes: denormals are treated as zero; no exception flags are produced.
module fma_lane_trunc
    import fma_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic [EXP_W+FRAC_W:0] op_c,
    input  logic                  int_sel,
    input  logic [EXP_W+FRAC_W:0] int_val,
    output logic                  out_valid,
    output logic [EXP_W+FRAC_W:0] out_res
);
    localparam int WIN_W = 4 * FRAC_W + 8;
    localparam int LZ_W  = $clog2(WIN_W + 1);
    localparam int EI_W  = EXP_W + 4;

    logic                   al_valid, al_sticky, al_sp, al_sc;
    logic [WIN_W-1:0]       al_x, al_y;
    logic signed [EI_W-1:0] al_emax;
    fma_spec_t              al_spec;

    logic                   lz_valid, lz_sign, lz_zneg;
    logic [WIN_W-1:0]       lz_sum;
    logic [LZ_W-1:0]        lz_cnt;
    logic signed [EI_W-1:0] lz_emax;
    fma_spec_t              lz_spec;

    fma_mul_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_mul_align (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .al_valid(al_valid), .al_x(al_x), .al_y(al_y), .al_sticky(al_sticky),
        .al_emax(al_emax), .al_sp(al_sp), .al_sc(al_sc), .al_spec(al_spec));

    fma_add_lzc #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_add_lzc (
        .clk(clk), .rst_n(rst_n), .al_valid(al_valid), .al_x(al_x), .al_y(al_y),
        .al_sticky(al_sticky), .al_emax(al_emax), .al_sp(al_sp), .al_sc(al_sc),
        .al_spec(al_spec), .lz_valid(lz_valid), .lz_sum(lz_sum), .lz_cnt(lz_cnt),
        .lz_sign(lz_sign), .lz_zneg(lz_zneg), .lz_emax(lz_emax), .lz_spec(lz_spec));

    fma_norm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm_pack (
        .clk(clk), .rst_n(rst_n), .lz_valid(lz_valid), .lz_sum(lz_sum),
        .lz_cnt(lz_cnt), .lz_sign(lz_sign), .lz_zneg(lz_zneg), .lz_emax(lz_emax),
        .lz_spec(lz_spec), .int_sel(int_sel), .int_val(int_val),
        .out_valid(out_valid), .out_res(out_res));

    // Cycles since reset, saturating, to keep $past windows inside reset-free time.
    logic [2:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n) warm <= '0;
        else if (warm != 3'd7) warm <= warm + 3'd1;
    end

    // Valid follows the input six edges later, or the merge one edge later. (R2)
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 3'd6) |-> (out_valid == ($past(in_valid, 6) | $past(int_sel))));
    // Merged integer result passes unchanged. (R8)
    assert_int_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 3'd1 && $past(int_sel)) |-> (out_valid && out_res == $past(int_val)));
endmodule

// File: tb/sim_fma_lane_trunc.sv
`timescale 1ns/1ps
// Directed bench for fma_lane_trunc: one task per scenario.
module sim_fma_lane_trunc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        int_sel = 1'b0;
    logic [31:0] int_val = '0;
    logic        out_valid;
    logic [31:0] out_res;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fma_lane_trunc u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .int_sel(int_sel), .int_val(int_val),
        .out_valid(out_valid), .out_res(out_res));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // One operation; result due after the sixth edge counting the capturing edge.
    task automatic t_op(input logic [31:0] a, b, c, exp, input string tag);
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        chk(tag, out_res, exp);
    endtask

    // R9: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R9 reset result", out_res, 32'd0);
        rst_n = 1'b1;
    endtask

    // R2: valid low one cycle early, high on time, low one cycle late
    task automatic t_latency();
        @(negedge clk);
        op_a = 32'h40000000; op_b = 32'h40400000; op_c = 32'h3F800000; in_valid = 1'b1;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (k == 5) chk("R2 early valid", {31'd0, out_valid}, 32'd0);
            if (k == 6) begin
                chk("R2 on-time valid", {31'd0, out_valid}, 32'd1);
                chk("R2 on-time result", out_res, 32'h40E00000);
            end
            if (k == 7) chk("R2 late valid", {31'd0, out_valid}, 32'd0);
        end
    endtask

    // R2/R1: back-to-back issue, one result per cycle
    task automatic t_stream();
        logic [31:0] va [4] = '{32'h3F800000, 32'h3FC00000, 32'h40000000, 32'hBF800001};
        logic [31:0] vb [4] = '{32'h3F800000, 32'h3FC00000, 32'h3F000000, 32'h3F800001};
        logic [31:0] vc [4] = '{32'h3F800000, 32'h00000000, 32'h3F800000, 32'h00000000};
        logic [31:0] ve [4] = '{32'h40000000, 32'h40100000, 32'h40000000, 32'hBF800002};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            op_a = va[i]; op_b = vb[i]; op_c = vc[i]; in_valid = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk($sformatf("R2 stream valid %0d", i), {31'd0, out_valid}, 32'd1);
            chk($sformatf("R1 stream result %0d", i), out_res, ve[i]);
            @(negedge clk);
        end
        chk("R2 stream drained", {31'd0, out_valid}, 32'd0);
    endtask

    // R8: integer merge one edge after int_sel
    task automatic t_int();
        @(negedge clk);
        int_sel = 1'b1; int_val = 32'h12345678;
        @(negedge clk);
        int_sel = 1'b0;
        chk("R8 merge valid", {31'd0, out_valid}, 32'd1);
        chk("R8 merge value", out_res, 32'h12345678);
        @(negedge clk);
        chk("R8 merge one cycle only", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_latency();
        // R1: exact truncation, including sticky below the window
        t_op(32'h40000000, 32'h40400000, 32'h3F800000, 32'h40E00000, "R1 2*3+1");
        t_op(32'h3F800001, 32'h3F800001, 32'h00000000, 32'h3F800002, "R1 square trunc");
        t_op(32'h3F800000, 32'h3F800000, 32'h17800000, 32'h3F800000, "R1 tiny add");
        t_op(32'h3F800000, 32'h3F800000, 32'h97800000, 32'h3F7FFFFF, "R1 tiny sub sticky");
        t_op(32'h30800000, 32'h3F800000, 32'hBF800000, 32'hBF7FFFFF, "R1 addend dominates");
        // R10: cancellation
        t_op(32'h3FC00000, 32'h3F800000, 32'hBF800000, 32'h3F000000, "R10 1.5-1");
        t_op(32'h40400000, 32'h3F800000, 32'hC03FFFFF, 32'h34800000, "R10 deep cancel");
        // R3: NaN cases
        t_op(32'h7F800001, 32'h3F800000, 32'h3F800000, 32'h7FC00000, "R3 nan in");
        t_op(32'h7F800000, 32'h00000000, 32'h3F800000, 32'h7FC00000, "R3 inf*0");
        t_op(32'h7F800000, 32'h3F800000, 32'hFF800000, 32'h7FC00000, "R3 inf-inf");
        // R4: infinities
        t_op(32'h7F800000, 32'h40000000, 32'h3F800000, 32'h7F800000, "R4 inf product");
        t_op(32'h3F800000, 32'h3F800000, 32'hFF800000, 32'hFF800000, "R4 inf addend");
        // R5: zero sign
        t_op(32'h3F800000, 32'h3F800000, 32'hBF800000, 32'h00000000, "R5 exact cancel");
        t_op(32'h80000000, 32'h3F800000, 32'h80000000, 32'h80000000, "R5 neg zeros");
        // R6: saturation
        t_op(32'h7F7FFFFF, 32'h40000000, 32'h00000000, 32'h7F7FFFFF, "R6 pos sat");
        t_op(32'h7F7FFFFF, 32'hC0000000, 32'h00000000, 32'hFF7FFFFF, "R6 neg sat");
        // R7: denormal in, flush out
        t_op(32'h00400000, 32'h3F800000, 32'h3F800000, 32'h3F800000, "R7 denorm in");
        t_op(32'h00800000, 32'h3F000000, 32'h00000000, 32'h00000000, "R7 flush pos");
        t_op(32'h00800000, 32'hBF000000, 32'h00000000, 32'h80000000, "R7 flush neg");
        t_stream();
        t_int();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule